// File: doc/BRIEF.md
# Floating-Point Structural Hazard Tracker

This block sits in the issue stage of an in-order core. It decides whether the floating-point operation offered this cycle can enter its execution resources, or whether it must wait because a resource is still held by an earlier operation. Two resources are tracked. The first is the shared multiply pipe, which longer multiplies keep busy for several cycles. The second is the divide/square-root unit, which is not pipelined. A vector multiply also keeps the whole issue stage closed for one extra cycle. Each resource has its own down-counter. The counter is loaded when an operation is accepted and falls by one every cycle until it reaches zero.

The issue stage presents one operation class per cycle as a one-hot vector qualified by `op_valid`. The tracker answers combinationally with `op_ready`. An operation is accepted on a rising clock edge where `op_valid` and `op_ready` are both high. While `op_ready` is low the issuer must hold the same class and valid, which is ordinary back-pressure. `stall` is a plain status pin equal to `op_valid && !op_ready`. `op_ready` depends only on the offered class and on the counters, never on `op_valid`. Divides finish out of order with respect to later short operations, so a busy divider never holds back multiplies or additions.

Top module: `fp_struct_hazard`

## Requirements
- R1: After reset every resource is free. The first offered operation of any class sees `op_ready`=1 and `stall`=0, and an active reset clears any occupancy in progress.
- R2: Add-class operations are never held back by the multiply pipe or the divider. These are class bit 0 (add, compare, convert) and class bit 1 (constant). Accepting one leaves the multiply pipe free for the next cycle.
- R3: Single-precision multiply (bit 2) and single-precision MAC (bit 3) hold the multiply pipe only in their issue cycle. A multiply-class operation offered in the very next cycle is accepted without waiting.
- R4: Double-precision multiply (bit 4) and double-precision MAC (bit 5) hold the multiply pipe for 3 cycles after their issue cycle. A multiply-class operation offered straight after waits exactly 3 cycles.
- R5: Double-precision fused MAC (bit 6) holds the multiply pipe for 4 cycles after its issue cycle. A multiply-class operation offered straight after waits exactly 4 cycles.
- R6: Operations outside the multiply class can be accepted while a double-precision multiply still holds the pipe. Doing so does not lengthen the remaining hold.
- R7: Single-precision divide (bit 7) holds the divider for 13 cycles after its issue cycle, and double-precision divide (bit 8) for 28. A divide offered straight after waits exactly that many cycles.
- R8: A busy divider does not hold back multiply-class or add-class operations.
- R9: Vector multiply (bit 9) is multiply-class. In the cycle after its issue no operation of any class is accepted. It holds the multiply pipe for that cycle as well.
- R10: Handshake rules. Acceptance happens when `op_valid && op_ready`, `stall` equals `op_valid && !op_ready`, `op_ready` does not depend on `op_valid`, and `op_class` is one-hot while `op_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is offered this cycle |
| op_class | input | 10 | One-hot operation class (bit map in R2 to R9) |
| op_ready | output | 1 | The offered class may issue this cycle |
| stall | output | 1 | The offered operation must wait |

## Verification
`op_ready` and `stall` are combinational, so the bench checks them in the same cycle the class is offered, shortly after the falling edge. Counters load at the acceptance edge, so a hold of N extra cycles means a dependent operation offered in the next cycle is refused for exactly N cycles and accepted at the (N+1)-th edge. The bench offers each dependent operation immediately after the previous acceptance. It counts the refused cycles and compares that count with the hold length from the requirements. Between scenarios the bench idles long enough for every counter to drain.

// File: rtl/fph_pkg.sv
package fph_pkg;
  localparam int NCLS = 10;

  // one-hot class bit positions
  localparam int K_ADD   = 0;
  localparam int K_CONST = 1;
  localparam int K_MULS  = 2;
  localparam int K_MACS  = 3;
  localparam int K_MULD  = 4;
  localparam int K_MACD  = 5;
  localparam int K_FMAD  = 6;
  localparam int K_DIVS  = 7;
  localparam int K_DIVD  = 8;
  localparam int K_VMUL  = 9;

  localparam logic [NCLS-1:0] MUL_SET =
    (NCLS'(1) << K_MULS) | (NCLS'(1) << K_MACS) | (NCLS'(1) << K_MULD) |
    (NCLS'(1) << K_MACD) | (NCLS'(1) << K_FMAD) | (NCLS'(1) << K_VMUL);
  localparam logic [NCLS-1:0] DIV_SET =
    (NCLS'(1) << K_DIVS) | (NCLS'(1) << K_DIVD);
endpackage

// File: rtl/fph_decode.sv
module fph_decode
  import fph_pkg::*;
#(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned MULD_X = 3,
  parameter int unsigned FMAD_X = 4,
  parameter int unsigned VMUL_X = 1,
  parameter int unsigned DIVS_X = 13,
  parameter int unsigned DIVD_X = 28
) (
  input  logic [NCLS-1:0]  cls,
  output logic             is_mul,
  output logic             is_div,
  output logic             is_vec,
  output logic [CNT_W-1:0] mul_hold,
  output logic [CNT_W-1:0] div_hold,
  output logic [CNT_W-1:0] slot_hold
);
  always_comb begin
    is_mul = |(cls & MUL_SET);
    is_div = |(cls & DIV_SET);
    is_vec = cls[K_VMUL];

    mul_hold = '0;
    if (cls[K_MULD] || cls[K_MACD]) mul_hold = CNT_W'(MULD_X);
    if (cls[K_FMAD])                mul_hold = CNT_W'(FMAD_X);
    if (cls[K_VMUL])                mul_hold = CNT_W'(VMUL_X);

    div_hold = '0;
    if (cls[K_DIVS]) div_hold = CNT_W'(DIVS_X);
    if (cls[K_DIVD]) div_hold = CNT_W'(DIVD_X);

    slot_hold = CNT_W'(VMUL_X);
  end
endmodule

// File: rtl/fph_busy_ctr.sv
module fph_busy_ctr #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/fp_struct_hazard.sv
module fp_struct_hazard
  import fph_pkg::*;
#(
  parameter int unsigned MULD_X = 3,
  parameter int unsigned FMAD_X = 4,
  parameter int unsigned VMUL_X = 1,
  parameter int unsigned DIVS_X = 13,
  parameter int unsigned DIVD_X = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [NCLS-1:0] op_class,
  output logic            op_ready,
  output logic            stall
);
  localparam int unsigned MAX_A = (MULD_X > FMAD_X) ? MULD_X : FMAD_X;
  localparam int unsigned MAX_B = (DIVS_X > DIVD_X) ? DIVS_X : DIVD_X;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_H = (MAX_C > VMUL_X) ? MAX_C : VMUL_X;
  localparam int unsigned CNT_W = $clog2(MAX_H + 1);
  localparam int unsigned NRES  = 3; // 0 multiply pipe, 1 divider, 2 issue slots

  logic             is_mul, is_div, is_vec;
  logic [CNT_W-1:0] mul_hold, div_hold, slot_hold;
  logic             accept;
  logic [NRES-1:0]  res_load;
  logic [NRES-1:0][CNT_W-1:0] res_val;
  logic [NRES-1:0]  res_busy;
  logic             mul_busy, div_busy, slot_busy, conflict;

  fph_decode #(
    .CNT_W(CNT_W), .MULD_X(MULD_X), .FMAD_X(FMAD_X), .VMUL_X(VMUL_X),
    .DIVS_X(DIVS_X), .DIVD_X(DIVD_X)
  ) u_dec (
    .cls(op_class), .is_mul(is_mul), .is_div(is_div), .is_vec(is_vec),
    .mul_hold(mul_hold), .div_hold(div_hold), .slot_hold(slot_hold)
  );

  assign accept = op_valid && op_ready;

  assign res_load = {accept && is_vec, accept && is_div, accept && is_mul};
  assign res_val  = {slot_hold, div_hold, mul_hold};

  for (genvar g = 0; g < NRES; g++) begin : g_res
    fph_busy_ctr #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .load(res_load[g]), .load_val(res_val[g]),
      .busy(res_busy[g])
    );
  end

  assign mul_busy  = res_busy[0];
  assign div_busy  = res_busy[1];
  assign slot_busy = res_busy[2];

  assign conflict = slot_busy || (is_mul && mul_busy) || (is_div && div_busy);
  assign op_ready = !conflict;
  assign stall    = op_valid && conflict;
endmodule

// File: rtl/fph_checker.sv
module fph_checker
  import fph_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [NCLS-1:0] op_class,
  input logic            op_ready,
  input logic            stall,
  input logic            slot_busy
);
  logic acc;
  assign acc = op_valid && op_ready;

  // R1
  reset_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (op_ready || slot_busy == 1'b0));

  // R2
  add_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_class[K_ADD] || op_class[K_CONST]) && !slot_busy) |-> op_ready);

  // R4
  muld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op_class[K_MULD] || op_class[K_MACD])) |=>
      (!(op_valid && |(op_class & MUL_SET)) || stall));

  // R5
  fmad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_class[K_FMAD]) |=> (!(op_valid && |(op_class & MUL_SET)) || stall));

  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && |(op_class & DIV_SET)) |=> (!(op_valid && |(op_class & DIV_SET)) || stall));

  // R9
  vec_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_class[K_VMUL]) |=> !op_ready);

  // R10
  stall_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall == (op_valid && !op_ready));

  // R10
  onehot_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $onehot0(op_class));
endmodule

bind fp_struct_hazard fph_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
  .op_ready(op_ready), .stall(stall), .slot_busy(slot_busy)
);

// File: tb/fp_struct_hazard_test.sv
module fp_struct_hazard_test;
  // class bits as stated in the requirements
  localparam logic [9:0] C_ADD = 10'b1 << 0, C_CONST = 10'b1 << 1,
    C_MULS = 10'b1 << 2, C_MACS = 10'b1 << 3, C_MULD = 10'b1 << 4,
    C_MACD = 10'b1 << 5, C_FMAD = 10'b1 << 6, C_DIVS = 10'b1 << 7,
    C_DIVD = 10'b1 << 8, C_VMUL = 10'b1 << 9;

  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [9:0] op_class = '0;
  logic op_ready, stall;
  int n_chk = 0, n_bad = 0;

  fp_struct_hazard uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid),
    .op_class(op_class), .op_ready(op_ready), .stall(stall));

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // offer a class right away, count refused cycles until accepted
  task automatic issue(input logic [9:0] cls, output int waited);
    waited = 0;
    @(negedge clk);
    op_valid = 1'b1; op_class = cls; #1;
    while (!op_ready) begin
      waited++;
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    op_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    op_valid = 1'b1; op_class = C_MULD; #1;
    chk("R1 ready after reset", op_ready, 1);
    chk("R1 stall after reset", stall, 0);
    op_valid = 1'b0;
  endtask

  task automatic t_single();
    int w;
    issue(C_MULS, w);
    issue(C_MACS, w); chk("R3 MACS after MULS", w, 0);
    issue(C_MULS, w); chk("R3 MULS after MACS", w, 0);
    idle(6);
  endtask

  task automatic t_double();
    int w;
    issue(C_MULD, w);
    issue(C_MULS, w); chk("R4 MULS after MULD", w, 3);
    idle(6);
    issue(C_MACD, w);
    issue(C_MACD, w); chk("R4 MACD after MACD", w, 3);
    idle(6);
    issue(C_FMAD, w);
    issue(C_MULD, w); chk("R5 MULD after FMAD", w, 4);
    idle(6);
  endtask

  task automatic t_interleave();
    int w;
    issue(C_MULD, w);
    issue(C_ADD, w);   chk("R6 ADD during MULD hold", w, 0);
    issue(C_MACS, w);  chk("R6 MACS hold not lengthened", w, 2);
    issue(C_MULD, w);
    issue(C_CONST, w); chk("R2 CONST during MULD hold", w, 0);
    issue(C_MULS, w);  chk("R2 CONST leaves pipe hold as is", w, 2);
    idle(6);
    issue(C_ADD, w);
    issue(C_MULS, w);  chk("R2 MULS after ADD", w, 0);
    idle(6);
  endtask

  task automatic t_divide();
    int w;
    issue(C_DIVS, w);
    issue(C_DIVS, w); chk("R7 DIVS after DIVS", w, 13);
    idle(20);
    issue(C_DIVD, w);
    issue(C_DIVS, w); chk("R7 DIVS after DIVD", w, 28);
    idle(20);
    issue(C_DIVD, w);
    issue(C_MULD, w); chk("R8 MULD during divide", w, 0);
    issue(C_MULS, w); chk("R8 MULS after MULD under divide", w, 3);
    issue(C_ADD, w);  chk("R8 ADD during divide", w, 0);
    issue(C_DIVD, w); chk("R8 divide hold still counts", w, 22);
    idle(35);
  endtask

  task automatic t_vector();
    int w;
    issue(C_VMUL, w);
    issue(C_ADD, w);  chk("R9 ADD after VMUL", w, 1);
    issue(C_VMUL, w);
    issue(C_DIVS, w); chk("R9 DIVS after VMUL", w, 1);
    idle(20);
    issue(C_VMUL, w);
    issue(C_MULS, w); chk("R9 MULS after VMUL", w, 1);
    idle(4);
  endtask

  task automatic t_handshake();
    int w;
    issue(C_MULD, w);
    @(negedge clk);
    op_valid = 1'b1; op_class = C_MULS; #1;
    chk("R10 stall while blocked", stall, 1);
    chk("R10 ready low while blocked", op_ready, 0);
    op_valid = 1'b0; #1;
    chk("R10 stall low without valid", stall, 0);
    chk("R10 ready ignores valid", op_ready, 0);
    idle(6);
  endtask

  task automatic t_reset_clear();
    int w;
    issue(C_DIVD, w);
    issue(C_FMAD, w);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    issue(C_DIVS, w); chk("R1 reset clears divider", w, 0);
    issue(C_MULS, w); chk("R1 reset clears multiply pipe", w, 0);
    idle(20);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_double();
    t_interleave();
    t_divide();
    t_vector();
    t_handshake();
    t_reset_clear();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    finish_run();
  end
endmodule